// File: doc/BRIEF.md
# Serial-Bus Controller Register Bank

This block is the software-visible register file of a serial-bus controller. It sits between a simple single-cycle read/write port and the protocol engine. It holds a command word, three bus-timing words, an interrupt word and a data word, and it passes a read-only status word from the engine through to the port. The protocol engine itself is not part of this block.

The command word and the interrupt word can each be reached at three addresses. The base address replaces the word. The set alias ORs the written ones into the word. The clear alias removes the written ones. Software can therefore change single bits without a read-modify-write sequence.

The interrupt word carries eight event flags in its low byte and their enables one byte higher. The engine raises the flags with single-cycle pulses, and software acknowledges them by writing ones. A level interrupt is asserted while any enabled flag is pending. A command bit releases an engine that has halted on a missing acknowledge, and another command bit puts the whole bank back to its default state.

Top module: `sbus_regbank`

## Requirements
- R1: After reset, the command, interrupt and data words read 0, the three timing outputs equal their reset parameters, and both `irq` and `nak_release` are low.
- R2: A write to 0x00 replaces the command word, which appears on `cmd_out` after that clock edge. A read of 0x00, 0x04 or 0x08 returns the command word on `bus_rdata` one cycle after the request.
- R3: A write to 0x04 ORs the written ones into the command word. Bits written as zero keep their value.
- R4: A write to 0x08 clears the command bits written as one. Bits written as zero keep their value.
- R5: The timing words at 0x10, 0x20 and 0x30 are plain read/write and drive `tim0_out`, `tim1_out` and `tim2_out`.
- R6: Flag bit i (bits 7..0 of the interrupt word) is set by a pulse on `eng_evt[i]`. A write to 0x40 clears the flags written as one and loads bits 15..8 as enables. If an event and an acknowledge of the same flag fall in one cycle, the flag stays set.
- R7: A write to 0x44 ORs ones into both the flags and the enables. A write to 0x48 clears them. A read of 0x44 or 0x48 returns the interrupt word.
- R8: `irq` is high exactly while some flag i and its enable at bit i+8 are both 1.
- R9: Writing 1 to bit 28 at 0x40 or 0x44 gives a one-cycle `nak_release` pulse after the write edge. Bit 28 reads 0, and a write of bit 28 to 0x48 gives no pulse.
- R10: A read of 0x50 returns `eng_status`. A write to 0x50 changes no stored word.
- R11: The data word is at 0xA0 (at 0x60 when `LEGACY_MAP` is 1) and drives `data_out`. A read of any unmapped address returns 0, and a write to one has no effect.
- R12: Writing 1 to bit 31 at 0x00 or 0x04 returns every stored word to its reset value after that edge, and bit 31 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| eng_evt | input | 8 | Single-cycle event pulses from the engine |
| eng_status | input | 32 | Live engine status |
| cmd_out | output | 32 | Command word |
| tim0_out | output | 32 | First timing word |
| tim1_out | output | 32 | Second timing word |
| tim2_out | output | 32 | Third timing word |
| data_out | output | 32 | Data word |
| nak_release | output | 1 | One-cycle release pulse |
| irq | output | 1 | Level interrupt |

## Verification
The command word is tried with three kinds of write: plain writes, set-alias writes and clear-alias writes. The data patterns mix bits that are already 1 with bits that are still 0, so an alias that replaces the word instead of merging into it gives a wrong read-back. The interrupt word is tried with flags that have no enable, with enables that have no flag, and with matched pairs. This separates a correct per-bit AND from a plain OR of flags, and it catches an enable taken from the wrong byte. A write that acknowledges a flag in the same cycle as a new event on that flag checks which one takes priority. Writes to the status address, to the unused data address and to the clear-alias release bit check that these accesses change no output.

// File: rtl/sbus_regbank_pkg.sv
package sbus_regbank_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned NFLAG     = 8;
  localparam int unsigned NTIM      = 3;
  localparam int unsigned ENA_SHIFT = 8;
  localparam int unsigned NAK_BIT   = 28;
  localparam int unsigned SRST_BIT  = 31;

  localparam int unsigned OFF_CMD      = 'h00;
  localparam int unsigned OFF_CMD_SET  = 'h04;
  localparam int unsigned OFF_CMD_CLR  = 'h08;
  localparam int unsigned OFF_TIM_BASE = 'h10;
  localparam int unsigned TIM_STRIDE   = 'h10;
  localparam int unsigned OFF_IRQ      = 'h40;
  localparam int unsigned OFF_IRQ_SET  = 'h44;
  localparam int unsigned OFF_IRQ_CLR  = 'h48;
  localparam int unsigned OFF_STAT     = 'h50;
  localparam int unsigned OFF_DATA_NEW = 'hA0;
  localparam int unsigned OFF_DATA_OLD = 'h60;

  typedef enum logic [2:0] {
    RS_NONE, RS_CMD, RS_TIM0, RS_TIM1, RS_TIM2, RS_IRQ, RS_STAT, RS_DATA
  } rsel_e;

  typedef struct packed {
    logic            cmd_plain;
    logic            cmd_set;
    logic            cmd_clr;
    logic [NTIM-1:0] tim_wr;
    logic            irq_plain;
    logic            irq_set;
    logic            irq_clr;
    logic            dat_wr;
    rsel_e           rsel;
  } dec_t;
endpackage

// File: rtl/sbus_addr_decode.sv
module sbus_addr_decode
  import sbus_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter bit          LEGACY_MAP = 1'b0
) (
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int unsigned DATA_OFF = LEGACY_MAP ? OFF_DATA_OLD : OFF_DATA_NEW;

  logic wr;
  assign wr = en & we;

  always_comb begin
    dec      = '0;
    dec.rsel = RS_NONE;
    if (en) begin
      if (addr == ADDR_W'(OFF_CMD)) begin
        dec.cmd_plain = wr;
        dec.rsel      = RS_CMD;
      end else if (addr == ADDR_W'(OFF_CMD_SET)) begin
        dec.cmd_set = wr;
        dec.rsel    = RS_CMD;
      end else if (addr == ADDR_W'(OFF_CMD_CLR)) begin
        dec.cmd_clr = wr;
        dec.rsel    = RS_CMD;
      end else if (addr == ADDR_W'(OFF_IRQ)) begin
        dec.irq_plain = wr;
        dec.rsel      = RS_IRQ;
      end else if (addr == ADDR_W'(OFF_IRQ_SET)) begin
        dec.irq_set = wr;
        dec.rsel    = RS_IRQ;
      end else if (addr == ADDR_W'(OFF_IRQ_CLR)) begin
        dec.irq_clr = wr;
        dec.rsel    = RS_IRQ;
      end else if (addr == ADDR_W'(OFF_STAT)) begin
        dec.rsel = RS_STAT;
      end else if (addr == ADDR_W'(DATA_OFF)) begin
        dec.dat_wr = wr;
        dec.rsel   = RS_DATA;
      end
      for (int i = 0; i < NTIM; i++) begin
        if (addr == ADDR_W'(OFF_TIM_BASE + i * TIM_STRIDE)) begin
          dec.tim_wr[i] = wr;
          dec.rsel      = rsel_e'(int'(RS_TIM0) + i);
        end
      end
    end
  end
endmodule

// File: rtl/sbus_alias_reg.sv
module sbus_alias_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         wr_plain,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         ld;

  assign ld = srst | wr_plain | wr_set | wr_clr;

  always_comb begin
    q_n = q;
    if (srst)          q_n = RST;
    else if (wr_plain) q_n = wdata;
    else if (wr_set)   q_n = q | wdata;
    else if (wr_clr)   q_n = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (ld) q <= q_n;
  end

  p_set_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !srst) |=> ((q & $past(wdata)) == $past(wdata)));

  p_clr_remove_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !srst) |=> ((q & $past(wdata)) == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(srst || wr_plain || wr_set || wr_clr) |=> $stable(q));

  p_srst_default_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (q == RST));
endmodule

// File: rtl/sbus_irq_ctrl.sv
module sbus_irq_ctrl #(
  parameter int unsigned NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          wr_plain,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [NF-1:0] wflag,
  input  logic [NF-1:0] wen,
  input  logic          wnak,
  input  logic [NF-1:0] evt,
  output logic [NF-1:0] flag_q,
  output logic [NF-1:0] en_q,
  output logic          nak_rel_q,
  output logic          irq
);
  logic [NF-1:0] flag_n, en_n;
  logic          nak_n;
  logic          ld;

  assign ld = srst | wr_plain | wr_set | wr_clr | (|evt);

  always_comb begin
    flag_n = flag_q;
    en_n   = en_q;
    if (wr_plain) begin
      flag_n = flag_q & ~wflag;
      en_n   = wen;
    end else if (wr_set) begin
      flag_n = flag_q | wflag;
      en_n   = en_q | wen;
    end else if (wr_clr) begin
      flag_n = flag_q & ~wflag;
      en_n   = en_q & ~wen;
    end
    flag_n = flag_n | evt;
    nak_n  = (wr_plain | wr_set) & wnak & ~srst;
    if (srst) begin
      flag_n = '0;
      en_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else if (ld) begin
      flag_q <= flag_n;
      en_q   <= en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nak_rel_q <= 1'b0;
    else        nak_rel_q <= nak_n;
  end

  assign irq = |(flag_q & en_q);

  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt) && !srst) |=> ((flag_q & $past(evt)) == $past(evt)));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_plain && !srst) |=> ((flag_q & $past(wflag & ~evt)) == '0));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|evt) || wr_plain || wr_set));

  p_nak_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nak_rel_q |-> $past(wnak && (wr_plain || wr_set)));
endmodule

// File: rtl/sbus_regbank.sv
module sbus_regbank
  import sbus_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter bit          LEGACY_MAP = 1'b0,
  parameter logic [31:0] TIM0_RST   = 32'h0000_0000,
  parameter logic [31:0] TIM1_RST   = 32'h0000_0000,
  parameter logic [31:0] TIM2_RST   = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        eng_evt,
  input  logic [31:0]       eng_status,
  output logic [31:0]       cmd_out,
  output logic [31:0]       tim0_out,
  output logic [31:0]       tim1_out,
  output logic [31:0]       tim2_out,
  output logic [31:0]       data_out,
  output logic              nak_release,
  output logic              irq
);
  dec_t            dec;
  logic            srst;
  logic [DW-1:0]   cmd_q, dat_q;
  logic [DW-1:0]   tim_q [NTIM];
  logic [NFLAG-1:0] flag_q, en_q;
  logic [DW-1:0]   irq_word;
  logic [DW-1:0]   rd_n;
  logic            rd_ld;

  sbus_addr_decode #(.ADDR_W(ADDR_W), .LEGACY_MAP(LEGACY_MAP)) u_dec (
    .en   (bus_en),
    .we   (bus_we),
    .addr (bus_addr),
    .dec  (dec)
  );

  assign srst = (dec.cmd_plain | dec.cmd_set) & bus_wdata[SRST_BIT];

  sbus_alias_reg #(.W(DW), .RST('0)) u_cmd (
    .clk (clk), .rst_n (rst_n), .srst (srst),
    .wr_plain (dec.cmd_plain), .wr_set (dec.cmd_set), .wr_clr (dec.cmd_clr),
    .wdata (bus_wdata), .q (cmd_q)
  );

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    localparam logic [DW-1:0] TRST = (g == 0) ? TIM0_RST :
                                     (g == 1) ? TIM1_RST : TIM2_RST;
    sbus_alias_reg #(.W(DW), .RST(TRST)) u_tim (
      .clk (clk), .rst_n (rst_n), .srst (srst),
      .wr_plain (dec.tim_wr[g]), .wr_set (1'b0), .wr_clr (1'b0),
      .wdata (bus_wdata), .q (tim_q[g])
    );
  end

  sbus_alias_reg #(.W(DW), .RST('0)) u_dat (
    .clk (clk), .rst_n (rst_n), .srst (srst),
    .wr_plain (dec.dat_wr), .wr_set (1'b0), .wr_clr (1'b0),
    .wdata (bus_wdata), .q (dat_q)
  );

  sbus_irq_ctrl #(.NF(NFLAG)) u_irq (
    .clk (clk), .rst_n (rst_n), .srst (srst),
    .wr_plain (dec.irq_plain), .wr_set (dec.irq_set), .wr_clr (dec.irq_clr),
    .wflag (bus_wdata[NFLAG-1:0]),
    .wen   (bus_wdata[ENA_SHIFT+NFLAG-1:ENA_SHIFT]),
    .wnak  (bus_wdata[NAK_BIT]),
    .evt   (eng_evt),
    .flag_q (flag_q), .en_q (en_q), .nak_rel_q (nak_release), .irq (irq)
  );

  assign irq_word = DW'({en_q, flag_q});

  always_comb begin
    case (dec.rsel)
      RS_CMD:  rd_n = cmd_q;
      RS_TIM0: rd_n = tim_q[0];
      RS_TIM1: rd_n = tim_q[1];
      RS_TIM2: rd_n = tim_q[2];
      RS_IRQ:  rd_n = irq_word;
      RS_STAT: rd_n = eng_status;
      RS_DATA: rd_n = dat_q;
      default: rd_n = '0;
    endcase
  end

  assign rd_ld = bus_en & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ld) bus_rdata <= rd_n;
  end

  assign cmd_out  = cmd_q;
  assign tim0_out = tim_q[0];
  assign tim1_out = tim_q[1];
  assign tim2_out = tim_q[2];
  assign data_out = dat_q;

  p_srst_all_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cmd_out == '0 && data_out == '0 && !irq && !nak_release));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && dec.rsel == RS_NONE) |=> (bus_rdata == '0));

  p_stat_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && dec.rsel == RS_STAT) |=> (bus_rdata == $past(eng_status)));
endmodule

// File: tb/sbus_regbank_bench.sv
module sbus_regbank_bench;
  localparam logic [31:0] T0 = 32'h0012_0007;
  localparam logic [31:0] T1 = 32'h0034_0009;
  localparam logic [31:0] T2 = 32'h0070_0015;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  eng_evt = '0;
  logic [31:0] eng_status = '0;
  logic [31:0] cmd_out, tim0_out, tim1_out, tim2_out, data_out;
  logic        nak_release, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;

  always #10 clk = ~clk;

  sbus_regbank #(.ADDR_W(8), .LEGACY_MAP(1'b0),
                 .TIM0_RST(T0), .TIM1_RST(T1), .TIM2_RST(T2)) u_sbus_regbank (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_evt, .eng_status, .cmd_out, .tim0_out, .tim1_out, .tim2_out,
    .data_out, .nak_release, .irq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev = '0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; eng_evt = ev;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; eng_evt = '0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    eng_evt = ev;
    @(negedge clk);
    eng_evt = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // scoreboard monitor: a read issued at one edge is compared at the next falling edge
  always @(posedge clk) rd_fire <= bus_en && !bus_we;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", cmd_out, 32'h0);
    chk("R1 tim0", tim0_out, T0);
    chk("R1 tim1", tim1_out, T1);
    chk("R1 tim2", tim2_out, T2);
    chk("R1 data", data_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 nak", {31'h0, nak_release}, 32'h0);
    rd(8'h40, 32'h0, "R1 irq word");

    // R2 plain command write and alias reads
    wr(8'h00, 32'h0012_3456);
    chk("R2 cmd_out", cmd_out, 32'h0012_3456);
    rd(8'h00, 32'h0012_3456, "R2 read base");
    rd(8'h04, 32'h0012_3456, "R2 read set alias");
    rd(8'h08, 32'h0012_3456, "R2 read clr alias");

    // R3 set alias merges
    wr(8'h04, 32'h0300_0001);
    chk("R3 cmd_out", cmd_out, 32'h0312_3457);
    // R4 clear alias removes
    wr(8'h08, 32'h0010_0006);
    chk("R4 cmd_out", cmd_out, 32'h0302_3451);
    rd(8'h00, 32'h0302_3451, "R4 read back");

    // R5 timing words
    wr(8'h10, 32'hA5A5_0001);
    wr(8'h20, 32'h5A5A_0002);
    wr(8'h30, 32'h0F0F_0003);
    chk("R5 tim0", tim0_out, 32'hA5A5_0001);
    chk("R5 tim1", tim1_out, 32'h5A5A_0002);
    chk("R5 tim2", tim2_out, 32'h0F0F_0003);
    rd(8'h20, 32'h5A5A_0002, "R5 read tim1");

    // R6 events raise flags; no enable yet so R8 irq low
    pulse(8'h21);
    chk("R8 irq without enable", {31'h0, irq}, 32'h0);
    rd(8'h40, 32'h0000_0021, "R6 flags after event");
    wr(8'h40, 32'h0000_2001);
    chk("R8 irq enabled flag", {31'h0, irq}, 32'h1);
    rd(8'h40, 32'h0000_2020, "R6 ack bit0 load enable");
    wr(8'h40, 32'h0000_2020, 8'h20);
    rd(8'h40, 32'h0000_2020, "R6 event beats ack");
    wr(8'h40, 32'h0000_2020);
    chk("R8 irq after ack", {31'h0, irq}, 32'h0);

    // R7 interrupt aliases
    wr(8'h44, 32'h0000_4004);
    rd(8'h44, 32'h0000_6004, "R7 set alias");
    chk("R8 mismatched bits", {31'h0, irq}, 32'h0);
    wr(8'h44, 32'h0000_0040);
    chk("R8 matched bit6", {31'h0, irq}, 32'h1);
    wr(8'h48, 32'h0000_4000);
    chk("R8 enable cleared", {31'h0, irq}, 32'h0);
    rd(8'h48, 32'h0000_2044, "R7 clr alias enable");
    wr(8'h48, 32'h0000_0044);
    rd(8'h40, 32'h0000_2000, "R7 clr alias flags");

    // R9 release pulse
    wr(8'h44, 32'h1000_0000);
    chk("R9 pulse high", {31'h0, nak_release}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, nak_release}, 32'h0);
    wr(8'h40, 32'h1000_2000);
    chk("R9 pulse from base", {31'h0, nak_release}, 32'h1);
    rd(8'h40, 32'h0000_2000, "R9 bit28 reads zero");
    wr(8'h48, 32'h1000_0000);
    chk("R9 no pulse from clr", {31'h0, nak_release}, 32'h0);

    // R10 status passthrough, writes ignored
    eng_status = 32'hDEAD_BEEF;
    rd(8'h50, 32'hDEAD_BEEF, "R10 status read");
    wr(8'h50, 32'h0000_1234);
    rd(8'h50, 32'hDEAD_BEEF, "R10 status after write");
    chk("R10 cmd untouched", cmd_out, 32'h0302_3451);
    chk("R10 data untouched", data_out, 32'h0);

    // R11 data word and unmapped space
    wr(8'hA0, 32'hCAFE_F00D);
    chk("R11 data_out", data_out, 32'hCAFE_F00D);
    rd(8'hA0, 32'hCAFE_F00D, "R11 data read");
    wr(8'h60, 32'h1111_1111);
    chk("R11 legacy addr no effect", data_out, 32'hCAFE_F00D);
    rd(8'h60, 32'h0, "R11 legacy addr reads zero");
    rd(8'h0C, 32'h0, "R11 unmapped reads zero");

    // R12 soft reset through set alias, then through base
    pulse(8'h80);
    wr(8'h04, 32'h8000_0000);
    chk("R12 cmd", cmd_out, 32'h0);
    chk("R12 tim0", tim0_out, T0);
    chk("R12 tim2", tim2_out, T2);
    chk("R12 data", data_out, 32'h0);
    rd(8'h40, 32'h0, "R12 irq word");
    wr(8'h00, 32'h0000_00FF);
    wr(8'h00, 32'h8000_00FF);
    rd(8'h00, 32'h0, "R12 bit31 self clears");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule